// File: doc/BRIEF.md
# USB Device Clock Gating Controller

This block decides, cycle by cycle, which clocks of a USB device core may run. It drives three gate enables: one for the device-core clock, one for the bus-master clock used by DMA, and one for the slave-interface clock. The core clock is switched off on its own once the bus has been idle long enough to count as suspended. The bus-master clock is switched on by DMA traffic and held on for a minimum time afterwards. Software can hold either clock on with its own enable bit.

Each clock has a status bit that follows its gate after a short synchronizer delay. Software polls this bit before touching the core. The block also produces a need-clock signal for the chip power controller. This signal is low only when both status bits are clear. Bus activity during suspend raises it at once, so it serves as a wake request. A global peripheral power enable overrides everything else.

All timers count a millisecond tick input. All pins are plain level-sensitive control and status. There is no data stream, so no valid/ready handshake is involved.

Top module: `usb_clkgate_ctrl`

## Requirements
- R1: After reset, with `pwr_en` high, the block is not suspended, `core_gate_en` and `slave_gate_en` are high, `master_gate_en` is low, and both status bits are 0.
- R2: With no bus activity, `suspended` rises in the cycle after the IDLE_MS-th `ms_tick` since the last activity or reset. While suspended with `sw_core_en` low, `core_gate_en` is low.
- R3: A cycle with `bus_active` high restarts the idle count from zero. When `bus_active` and `ms_tick` are high in the same cycle, the restart wins and that tick is not counted.
- R4: In a cycle where `suspended` and `bus_active` are both high, `need_clk` is high in that same cycle. On the next cycle `suspended` is low and `core_gate_en` is high.
- R5: While `sw_core_en` and `pwr_en` are high, `core_gate_en` is high, whether or not the block is suspended.
- R6: A cycle with `dma_access` high makes `master_gate_en` high from the next cycle on. The gate goes low in the cycle after the (HOLD_MS+1)-th `ms_tick` that follows the last access. A `dma_access` in the same cycle as a tick reloads the hold, and that tick does not count.
- R7: While `sw_master_en` and `pwr_en` are high, `master_gate_en` is high.
- R8: `core_clk_on` and `master_clk_on` equal `core_gate_en` and `master_gate_en` as they were SYNC_STAGES (default 2) cycles earlier.
- R9: `need_clk` equals `core_clk_on | master_clk_on | (suspended & bus_active)`.
- R10: While `pwr_en` is low, all three gate enables are low in the same cycle. On the next clock the block is no longer suspended, the idle count is zero and the DMA hold has expired. A `dma_access` in such a cycle has no effect.
- R11: `slave_gate_en` equals `pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Global peripheral power enable |
| ms_tick | input | 1 | One-cycle pulse per millisecond/frame |
| bus_active | input | 1 | Bus activity seen this cycle |
| dma_access | input | 1 | DMA access strobe |
| sw_core_en | input | 1 | Software hold for the core clock |
| sw_master_en | input | 1 | Software hold for the bus-master clock |
| core_gate_en | output | 1 | Gate enable, device-core clock |
| master_gate_en | output | 1 | Gate enable, bus-master clock |
| slave_gate_en | output | 1 | Gate enable, slave-interface clock |
| core_clk_on | output | 1 | Status: core clock running |
| master_clk_on | output | 1 | Status: bus-master clock running |
| need_clk | output | 1 | Wake / keep-awake request to power control |
| suspended | output | 1 | Bus-idle suspend state |

## Verification
Two pairs of events can land in the same cycle. A millisecond tick can coincide with bus activity on the idle timer, and a tick can coincide with a DMA strobe on the hold timer. In both cases the restart or reload must win. The bench drives exactly these coincidences after partial counts. It then checks whether suspend arrives, and when the master gate drops, against a behavioural model compared every cycle. Bus activity that arrives in the very cycle suspend is active is also driven, to check the same-cycle need-clock response.

// File: rtl/usb_cg_pkg.sv
package usb_cg_pkg;
  typedef struct packed {
    logic core;
    logic master;
  } clk_pair_t;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/usb_cg_idle_timer.sv
module usb_cg_idle_timer #(
  parameter int unsigned IDLE_MS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic ms_tick,
  input  logic bus_active,
  output logic suspended
);
  localparam int unsigned CW = usb_cg_pkg::cnt_width(IDLE_MS);
  localparam logic [CW-1:0] LAST = CW'(IDLE_MS - 1);

  logic [CW-1:0] idle_cnt;
  logic          susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      susp_q   <= 1'b0;
    end else if (!pwr_en || bus_active) begin
      idle_cnt <= '0;
      susp_q   <= 1'b0;
    end else if (ms_tick && !susp_q) begin
      if (idle_cnt == LAST) begin
        susp_q <= 1'b1;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign suspended = susp_q;
endmodule

// File: rtl/usb_cg_hold_timer.sv
module usb_cg_hold_timer #(
  parameter int unsigned HOLD_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic ms_tick,
  input  logic dma_access,
  output logic hold_active
);
  localparam int unsigned LOADV = HOLD_MS + 1;
  localparam int unsigned CW    = usb_cg_pkg::cnt_width(LOADV);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!pwr_en) begin
      hold_cnt <= '0;
    end else if (dma_access) begin
      hold_cnt <= CW'(LOADV);
    end else if (ms_tick && (hold_cnt != '0)) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign hold_active = (hold_cnt != '0);
endmodule

// File: rtl/usb_cg_status_sync.sv
module usb_cg_status_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_clkgate_ctrl.sv
module usb_clkgate_ctrl #(
  parameter int unsigned IDLE_MS     = 3,
  parameter int unsigned HOLD_MS     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic ms_tick,
  input  logic bus_active,
  input  logic dma_access,
  input  logic sw_core_en,
  input  logic sw_master_en,
  output logic core_gate_en,
  output logic master_gate_en,
  output logic slave_gate_en,
  output logic core_clk_on,
  output logic master_clk_on,
  output logic need_clk,
  output logic suspended
);
  import usb_cg_pkg::*;

  logic      susp_w;
  logic      hold_w;
  clk_pair_t gate;
  clk_pair_t stat;

  usb_cg_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ms_tick(ms_tick),
    .bus_active(bus_active), .suspended(susp_w)
  );

  usb_cg_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ms_tick(ms_tick),
    .dma_access(dma_access), .hold_active(hold_w)
  );

  always_comb begin
    gate.core   = pwr_en && (sw_core_en || !susp_w);
    gate.master = pwr_en && (sw_master_en || hold_w);
  end

  usb_cg_status_sync #(.STAGES(SYNC_STAGES)) u_sync_core (
    .clk(clk), .rst_n(rst_n), .d(gate.core), .q(stat.core)
  );

  usb_cg_status_sync #(.STAGES(SYNC_STAGES)) u_sync_master (
    .clk(clk), .rst_n(rst_n), .d(gate.master), .q(stat.master)
  );

  assign core_gate_en   = gate.core;
  assign master_gate_en = gate.master;
  assign slave_gate_en  = pwr_en;
  assign core_clk_on    = stat.core;
  assign master_clk_on  = stat.master;
  assign suspended      = susp_w;
  assign need_clk       = stat.core || stat.master || (susp_w && bus_active);
endmodule

// File: rtl/usb_clkgate_ctrl_checker.sv
module usb_clkgate_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic pwr_en,
  input logic ms_tick,
  input logic bus_active,
  input logic dma_access,
  input logic sw_core_en,
  input logic sw_master_en,
  input logic core_gate_en,
  input logic master_gate_en,
  input logic slave_gate_en,
  input logic core_clk_on,
  input logic master_clk_on,
  input logic need_clk,
  input logic suspended
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_suspend_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(ms_tick));

  assert_wake_need_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && bus_active) |-> need_clk);

  assert_wake_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && bus_active) |=> !suspended);

  assert_sw_core_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_core_en && pwr_en) |-> core_gate_en);

  assert_dma_turn_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_access && pwr_en) |=> (master_gate_en || !pwr_en));

  assert_sw_master_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_master_en && pwr_en) |-> master_gate_en);

  assert_core_status_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (core_clk_on == $past(core_gate_en, 2)));

  assert_master_status_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (master_clk_on == $past(master_gate_en, 2)));

  assert_need_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !need_clk |-> (!core_clk_on && !master_clk_on));

  assert_power_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (!core_gate_en && !master_gate_en && !slave_gate_en));

  assert_power_off_unsuspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !suspended);
endmodule

bind usb_clkgate_ctrl usb_clkgate_ctrl_checker u_checker (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ms_tick(ms_tick),
  .bus_active(bus_active), .dma_access(dma_access), .sw_core_en(sw_core_en),
  .sw_master_en(sw_master_en), .core_gate_en(core_gate_en),
  .master_gate_en(master_gate_en), .slave_gate_en(slave_gate_en),
  .core_clk_on(core_clk_on), .master_clk_on(master_clk_on),
  .need_clk(need_clk), .suspended(suspended)
);

// File: tb/tb_usb_clkgate_ctrl.sv
module tb_usb_clkgate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_MS = 3;
  localparam int HOLD_MS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b1, ms_tick = 1'b0, bus_active = 1'b0, dma_access = 1'b0;
  logic sw_core_en = 1'b0, sw_master_en = 1'b0;
  logic core_gate_en, master_gate_en, slave_gate_en;
  logic core_clk_on, master_clk_on, need_clk, suspended;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int  m_idle = 0;
  bit  m_susp = 1'b0;
  int  m_hold = 0;
  bit  core_hist[$];
  bit  mast_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_clkgate_ctrl #(.IDLE_MS(IDLE_MS), .HOLD_MS(HOLD_MS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ms_tick(ms_tick),
    .bus_active(bus_active), .dma_access(dma_access), .sw_core_en(sw_core_en),
    .sw_master_en(sw_master_en), .core_gate_en(core_gate_en),
    .master_gate_en(master_gate_en), .slave_gate_en(slave_gate_en),
    .core_clk_on(core_clk_on), .master_clk_on(master_clk_on),
    .need_clk(need_clk), .suspended(suspended)
  );

  task automatic chk(input logic act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_core_gate();
    return pwr_en && (sw_core_en || !m_susp);
  endfunction
  function automatic bit m_mast_gate();
    return pwr_en && (sw_master_en || (m_hold != 0));
  endfunction

  task automatic model_reset();
    m_idle = 0; m_susp = 0; m_hold = 0;
    core_hist = '{0, 0};
    mast_hist = '{0, 0};
  endtask

  task automatic compare_all();
    chk(core_gate_en,   m_core_gate(), "R5 core_gate_en");
    chk(master_gate_en, m_mast_gate(), "R6 master_gate_en");
    chk(slave_gate_en,  pwr_en,        "R11 slave_gate_en");
    chk(suspended,      m_susp,        "R2 suspended");
    chk(core_clk_on,    core_hist[0],  "R8 core_clk_on");
    chk(master_clk_on,  mast_hist[0],  "R8 master_clk_on");
    chk(need_clk, core_hist[0] || mast_hist[0] || (m_susp && bus_active), "R9 need_clk");
  endtask

  task automatic model_clock();
    bit cg, mg;
    cg = m_core_gate();
    mg = m_mast_gate();
    if (!rst_n) begin
      model_reset();
      return;
    end
    core_hist.push_back(cg); void'(core_hist.pop_front());
    mast_hist.push_back(mg); void'(mast_hist.pop_front());
    if (!pwr_en || bus_active) begin
      m_idle = 0; m_susp = 0;
    end else if (ms_tick && !m_susp) begin
      m_idle++;
      if (m_idle >= IDLE_MS) m_susp = 1;
    end
    if (!pwr_en) m_hold = 0;
    else if (dma_access) m_hold = HOLD_MS + 1;
    else if (ms_tick && m_hold > 0) m_hold--;
  endtask

  // one cycle: drive, settle, compare, clock model, return at negedge
  task automatic step(input bit b, input bit d, input bit t);
    bus_active = b; dma_access = d; ms_tick = t;
    #1;
    compare_all();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic tick_after(input int gap);
    idle(gap);
    step(0, 0, 1);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    step(0, 0, 0);
    step(0, 0, 0);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(suspended, 1'b0, "R1 suspended after reset");
    chk(core_gate_en, 1'b1, "R1 core gate after reset");
    chk(master_gate_en, 1'b0, "R1 master gate after reset");
    chk(core_clk_on, 1'b0, "R1 core status after reset");
    chk(master_clk_on, 1'b0, "R1 master status after reset");
    idle(3);

    // R2 idle to suspend
    tick_after(2); tick_after(2);
    chk(suspended, 1'b0, "R2 not yet suspended after 2 ticks");
    tick_after(2);
    #1 chk(suspended, 1'b1, "R2 suspended after 3rd tick");
    chk(core_gate_en, 1'b0, "R2 core gate off in suspend");
    idle(4);
    #1 chk(need_clk, 1'b0, "R9 need_clk low when clocks off");

    // R4 activity during suspend
    bus_active = 1'b1; #1;
    chk(need_clk, 1'b1, "R4 need_clk same cycle");
    step(1, 0, 0);
    #1 chk(suspended, 1'b0, "R4 suspend cleared next cycle");
    chk(core_gate_en, 1'b1, "R4 core gate back on");
    idle(3);

    // R3 activity coincident with tick restarts count
    tick_after(1); tick_after(1);
    step(1, 0, 1);
    tick_after(1); tick_after(1);
    #1 chk(suspended, 1'b0, "R3 restart wins over tick");
    tick_after(1);
    #1 chk(suspended, 1'b1, "R3 suspend after full count");

    // R5 software core hold while suspended
    sw_core_en = 1'b1;
    #1 chk(core_gate_en, 1'b1, "R5 sw hold in suspend");
    idle(3);
    #1 chk(core_clk_on, 1'b1, "R5 status set after sync");
    sw_core_en = 1'b0;
    idle(3);
    #1 chk(core_clk_on, 1'b0, "R8 core status cleared after gate off");

    // R6 DMA hold
    step(0, 1, 0);
    #1 chk(master_gate_en, 1'b1, "R6 on after dma");
    tick_after(2); tick_after(2);
    #1 chk(master_gate_en, 1'b1, "R6 still held after 2 ticks");
    tick_after(2);
    #1 chk(master_gate_en, 1'b0, "R6 off after 3rd tick");
    idle(3);
    step(0, 1, 0);
    tick_after(1);
    step(0, 1, 1);
    tick_after(1); tick_after(1);
    #1 chk(master_gate_en, 1'b1, "R6 reload wins over tick");
    tick_after(1);
    #1 chk(master_gate_en, 1'b0, "R6 off after reload expires");
    idle(3);

    // R7 software master hold
    sw_master_en = 1'b1;
    idle(2); tick_after(1); tick_after(1); tick_after(1); tick_after(1);
    #1 chk(master_gate_en, 1'b1, "R7 forced on");
    sw_master_en = 1'b0;
    idle(3);

    // R10 power removal, dma ignored
    step(1, 1, 0);
    pwr_en = 1'b0;
    #1 chk(slave_gate_en, 1'b0, "R10 slave off");
    chk(core_gate_en, 1'b0, "R10 core off");
    chk(master_gate_en, 1'b0, "R10 master off");
    step(0, 1, 0);
    step(0, 1, 1);
    idle(3);
    #1 chk(need_clk, 1'b0, "R10 need_clk low after power-off");
    pwr_en = 1'b1;
    #1 chk(master_gate_en, 1'b0, "R10 dma during power-off ignored");
    chk(suspended, 1'b0, "R10 not suspended after power-off");
    idle(3);
    sw_core_en = 1'b1;
    tick_after(0); tick_after(0); tick_after(0);
    sw_core_en = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule